// File: doc/BRIEF.md
# DSP Condition Flag Unit

This block produces one selectable condition bit, called DC here, after each operation of a DSP datapath. The datapath registers are 40 bits wide: a 32-bit main word with 8 guard bits above it. A 3-bit mode input picks the condition that DC reports. The modes are carry/borrow, negative, zero, destination overflow, signed greater-than and signed greater-or-equal. The rule for each mode depends on the class of the operation that just finished.

The datapath supplies the following inputs:

- the operation class;
- the full 40-bit guard-extended result;
- the sign bits of the two operands, as the adder saw them;
- the carry or borrow out;
- the last bit shifted out;
- a write enable.

The block does not compute arithmetic results. It derives two signals from the result and the operand signs:

- Over-range: the 40-bit operation overflowed as a signed operation.
- Destination overflow: the result no longer fits the 32-bit main word.

For a shift, the datapath drives both sign inputs with the sign of the shifted source. With that input, a change of sign counts as over-range.

DC is a register. It loads on a clock edge where the write enable is high and the mode is not reserved. Instruction decode and the conditional execution that consumes DC sit outside the block.

Top module: `dcf_flag_gen`

## Requirements
- R1: A synchronous active-high reset clears DC to 0, and reset takes priority over the write enable.
- R2: When the write enable is low, DC keeps its value across the clock edge.
- R3: Mode 3'b000 (carry/borrow) behaves by operation class:
  - op_class 2'b00 (arithmetic ALU) loads carry_out.
  - op_class 2'b10 (arithmetic shift) and 2'b11 (logical shift) load shift_out.
  - op_class 2'b01 (logical ALU) clears DC.
- R4: Mode 3'b001 (negative) loads a sign bit that depends on the class:
  - Classes 2'b00 and 2'b10 load result bit 39, the MSB including guard bits.
  - Classes 2'b01 and 2'b11 load result bit 31, the MSB of the main word.
- R5: Mode 3'b010 (zero) sets DC when all 40 result bits are zero and clears it otherwise, for every class.
- R6: Mode 3'b011 (overflow) depends on the class:
  - For classes 2'b00 and 2'b10, DC is set when result bits 39 down to 31 are not all equal.
  - For classes 2'b01 and 2'b11, DC is cleared.
- R7: Mode 3'b101 (signed greater-or-equal) depends on the class:
  - For classes 2'b00 and 2'b10, DC = NOT(result[39] XOR over-range). Over-range is (sign_a == sign_b) AND (result[39] != sign_a).
  - For classes 2'b01 and 2'b11, DC is cleared.
- R8: Mode 3'b100 (signed greater-than) depends on the class:
  - For classes 2'b00 and 2'b10, DC = NOT((result[39] XOR over-range) OR zero), where zero means all 40 result bits are zero.
  - For classes 2'b01 and 2'b11, DC is cleared.
- R9: Modes 3'b110 and 3'b111 are reserved. A write in a reserved mode leaves DC unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Update DC on this edge |
| mode | input | 3 | Condition select |
| op_class | input | 2 | 00 arithmetic ALU, 01 logical ALU, 10 arithmetic shift, 11 logical shift |
| result | input | 40 | Guard-extended result of the operation |
| sign_a | input | 1 | Sign of the first operand |
| sign_b | input | 1 | Sign of the effective second operand |
| carry_out | input | 1 | Carry or borrow out of the ALU |
| shift_out | input | 1 | Last bit shifted out |
| dc | output | 1 | Registered condition flag |

## Verification
Every result of this block passes through a single register. DC reflects a stimulus exactly one rising edge after that stimulus is applied. The bench changes inputs on a falling edge and compares DC on the next falling edge. One rising edge lies between those two points, so each comparison sees the response to exactly one stimulus. The hold behaviour for a low enable, a reserved mode and reset is checked the same way: one edge later, DC must match the value it had before the stimulus, or 0 after reset.

// File: rtl/dcf_pkg.sv
package dcf_pkg;

  typedef enum logic [2:0] {
    MODE_CARRY = 3'd0,
    MODE_NEG   = 3'd1,
    MODE_ZERO  = 3'd2,
    MODE_OVF   = 3'd3,
    MODE_GT    = 3'd4,
    MODE_GE    = 3'd5,
    MODE_RSV6  = 3'd6,
    MODE_RSV7  = 3'd7
  } dc_mode_e;

  typedef enum logic [1:0] {
    OP_ARITH  = 2'd0,
    OP_LOGIC  = 2'd1,
    OP_ASHIFT = 2'd2,
    OP_LSHIFT = 2'd3
  } op_class_e;

  // Condition bits derived from one result
  typedef struct packed {
    logic neg_full;   // MSB including guard bits
    logic neg_word;   // MSB of the main word
    logic is_zero;    // whole result is zero
    logic over_range; // signed overflow of the full-width operation
    logic dest_ovf;   // result does not fit the main word
  } cond_bits_t;

  // Arithmetic classes have bit 0 clear
  function automatic logic is_arith(input op_class_e c);
    return (c == OP_ARITH) || (c == OP_ASHIFT);
  endfunction

endpackage

// File: rtl/dcf_range_detect.sv
module dcf_range_detect
  import dcf_pkg::*;
#(
  parameter int WORD_W  = 32,
  parameter int GUARD_W = 8
) (
  input  logic [WORD_W+GUARD_W-1:0] result,
  input  logic                      sign_a,
  input  logic                      sign_b,
  output cond_bits_t                cond
);
  localparam int FULL_W = WORD_W + GUARD_W;
  localparam int TOP_W  = GUARD_W + 1;

  // Guard bits plus the main-word sign bit must all agree when the value fits
  logic [TOP_W-1:0] top_bits;
  assign top_bits = result[FULL_W-1:WORD_W-1];

  always_comb begin
    cond.neg_full   = result[FULL_W-1];
    cond.neg_word   = result[WORD_W-1];
    cond.is_zero    = ~|result;
    cond.over_range = (sign_a == sign_b) && (result[FULL_W-1] != sign_a);
    cond.dest_ovf   = (|top_bits) && !(&top_bits);
  end

  // A zero result always fits the destination
  always_comb begin
    if (cond.is_zero) begin
      AST_ZERO_FITS: assert (!cond.dest_ovf); // R6
    end
  end

endmodule

// File: rtl/dcf_mode_mux.sv
module dcf_mode_mux
  import dcf_pkg::*;
(
  input  dc_mode_e   mode,
  input  op_class_e  op_class,
  input  cond_bits_t cond,
  input  logic       carry_out,
  input  logic       shift_out,
  output logic       dc_next,
  output logic       load_ok
);
  logic arith;
  logic ge_val;

  assign arith  = is_arith(op_class);
  assign ge_val = !(cond.neg_full ^ cond.over_range);

  always_comb begin
    dc_next = 1'b0;
    load_ok = 1'b1;
    unique case (mode)
      MODE_CARRY: begin
        unique case (op_class)
          OP_ARITH:  dc_next = carry_out;
          OP_LOGIC:  dc_next = 1'b0;
          default:   dc_next = shift_out;
        endcase
      end
      MODE_NEG:  dc_next = arith ? cond.neg_full : cond.neg_word;
      MODE_ZERO: dc_next = cond.is_zero;
      MODE_OVF:  dc_next = arith && cond.dest_ovf;
      MODE_GT:   dc_next = arith && ge_val && !cond.is_zero;
      MODE_GE:   dc_next = arith && ge_val;
      default: begin
        dc_next = 1'b0;
        load_ok = 1'b0;
      end
    endcase
  end

endmodule

// File: rtl/dcf_flag_gen.sv
module dcf_flag_gen
  import dcf_pkg::*;
#(
  parameter int WORD_W  = 32,
  parameter int GUARD_W = 8,
  localparam int FULL_W = WORD_W + GUARD_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [2:0]        mode,
  input  logic [1:0]        op_class,
  input  logic [FULL_W-1:0] result,
  input  logic              sign_a,
  input  logic              sign_b,
  input  logic              carry_out,
  input  logic              shift_out,
  output logic              dc
);
  cond_bits_t cond;
  logic       dc_next;
  logic       load_ok;

  dcf_range_detect #(
    .WORD_W (WORD_W),
    .GUARD_W(GUARD_W)
  ) u_range (
    .result(result),
    .sign_a(sign_a),
    .sign_b(sign_b),
    .cond  (cond)
  );

  dcf_mode_mux u_mux (
    .mode     (dc_mode_e'(mode)),
    .op_class (op_class_e'(op_class)),
    .cond     (cond),
    .carry_out(carry_out),
    .shift_out(shift_out),
    .dc_next  (dc_next),
    .load_ok  (load_ok)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      dc <= 1'b0;
    end else if (wr_en && load_ok) begin
      dc <= dc_next;
    end
  end

  AST_RESET_CLEAR: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> !dc); // R1
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    !wr_en |=> $stable(dc)); // R2
  AST_CARRY_FOLLOW: assert property (@(posedge clk) disable iff (rst)
    (wr_en && mode == 3'd0 && op_class == 2'd0) |=> (dc == $past(carry_out))); // R3
  AST_LOGIC_NO_OVF: assert property (@(posedge clk) disable iff (rst)
    (wr_en && mode == 3'd3 && op_class[0]) |=> !dc); // R6
  AST_ZERO_NOT_GT: assert property (@(posedge clk) disable iff (rst)
    (wr_en && mode == 3'd4 && result == '0) |=> !dc); // R8
  AST_RESERVED_HOLD: assert property (@(posedge clk) disable iff (rst)
    (wr_en && mode[2:1] == 2'b11) |=> $stable(dc)); // R9

endmodule

// File: tb/sim_dcf_flag_gen.sv
module sim_dcf_flag_gen;
  localparam int FULL_W = 40;
  localparam int NVEC   = 21;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              wr_en = 1'b0;
  logic [2:0]        mode = '0;
  logic [1:0]        op_class = '0;
  logic [FULL_W-1:0] result = '0;
  logic              sign_a = 1'b0;
  logic              sign_b = 1'b0;
  logic              carry_out = 1'b0;
  logic              shift_out = 1'b0;
  logic              dc;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  dcf_flag_gen u0 (
    .clk(clk), .rst(rst), .wr_en(wr_en), .mode(mode), .op_class(op_class),
    .result(result), .sign_a(sign_a), .sign_b(sign_b),
    .carry_out(carry_out), .shift_out(shift_out), .dc(dc)
  );

  // Vector: {mode, op_class, sign_a, sign_b, carry_out, shift_out, result, expected}
  localparam logic [49:0] VEC [NVEC] = '{
    {3'd0, 2'd0, 1'b0, 1'b0, 1'b1, 1'b0, 40'h00_0000_0005, 1'b1},
    {3'd0, 2'd1, 1'b0, 1'b0, 1'b1, 1'b1, 40'h00_0000_0005, 1'b0},
    {3'd0, 2'd2, 1'b0, 1'b0, 1'b0, 1'b1, 40'h00_0000_0000, 1'b1},
    {3'd0, 2'd3, 1'b0, 1'b0, 1'b1, 1'b0, 40'h00_0000_0005, 1'b0},
    {3'd1, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 40'h80_0000_0000, 1'b1},
    {3'd1, 2'd1, 1'b0, 1'b0, 1'b0, 1'b0, 40'h80_0000_0000, 1'b0},
    {3'd1, 2'd3, 1'b0, 1'b0, 1'b0, 1'b0, 40'h00_8000_0000, 1'b1},
    {3'd1, 2'd2, 1'b0, 1'b0, 1'b0, 1'b0, 40'h00_8000_0000, 1'b0},
    {3'd2, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 40'h00_0000_0000, 1'b1},
    {3'd2, 2'd1, 1'b0, 1'b0, 1'b0, 1'b0, 40'h10_0000_0000, 1'b0},
    {3'd3, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 40'h00_8000_0000, 1'b1},
    {3'd3, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 40'hFF_8000_0000, 1'b0},
    {3'd3, 2'd1, 1'b0, 1'b0, 1'b0, 1'b0, 40'h00_8000_0000, 1'b0},
    {3'd5, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 40'h80_0000_0000, 1'b1},
    {3'd5, 2'd0, 1'b1, 1'b1, 1'b0, 1'b0, 40'h7F_FFFF_FFFF, 1'b0},
    {3'd4, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 40'h00_0000_0000, 1'b0},
    {3'd4, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 40'h00_0000_0001, 1'b1},
    {3'd4, 2'd2, 1'b1, 1'b1, 1'b0, 1'b0, 40'hFF_FFFF_FFFF, 1'b0},
    {3'd5, 2'd3, 1'b0, 1'b0, 1'b0, 1'b0, 40'h00_0000_0001, 1'b0},
    {3'd4, 2'd0, 1'b1, 1'b1, 1'b0, 1'b0, 40'h7F_FFFF_FFFF, 1'b0},
    {3'd4, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 40'h80_0000_0000, 1'b1}
  };

  // Reference model built from the requirements
  function automatic logic ref_dc(input logic [2:0] m, input logic [1:0] c,
                                  input logic sa, input logic sb, input logic cy,
                                  input logic sh, input logic [FULL_W-1:0] r,
                                  input logic prev);
    logic ar, ovr, dst, zr;
    ar  = !c[0];
    ovr = (sa == sb) && (r[39] != sa);
    dst = !((r[39:31] == 9'h000) || (r[39:31] == 9'h1FF));
    zr  = (r == '0);
    case (m)
      3'd0: ref_dc = (c == 2'd0) ? cy : (c == 2'd1) ? 1'b0 : sh;
      3'd1: ref_dc = ar ? r[39] : r[31];
      3'd2: ref_dc = zr;
      3'd3: ref_dc = ar ? dst : 1'b0;
      3'd4: ref_dc = ar ? !((r[39] ^ ovr) | zr) : 1'b0;
      3'd5: ref_dc = ar ? !(r[39] ^ ovr) : 1'b0;
      default: ref_dc = prev;
    endcase
  endfunction

  function automatic string req_of(input logic [2:0] m);
    case (m)
      3'd0: req_of = "R3";
      3'd1: req_of = "R4";
      3'd2: req_of = "R5";
      3'd3: req_of = "R6";
      3'd4: req_of = "R8";
      3'd5: req_of = "R7";
      default: req_of = "R9";
    endcase
  endfunction

  task automatic check(input string req, input logic exp);
    checks++;
    if (dc !== exp) begin
      errors++;
      $display("FAIL %s: dc=%0b expected=%0b (mode=%0d op=%0d result=%h)",
               req, dc, exp, mode, op_class, result);
    end
  endtask

  // Drive on a falling edge; the result is due after the next rising edge
  task automatic apply(input logic we, input logic [2:0] m, input logic [1:0] c,
                       input logic sa, input logic sb, input logic cy,
                       input logic sh, input logic [FULL_W-1:0] r);
    @(negedge clk);
    wr_en = we; mode = m; op_class = c; sign_a = sa; sign_b = sb;
    carry_out = cy; shift_out = sh; result = r;
    @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: dc=%0b expected=run end", dc);
    finish_run();
  end

  localparam logic [FULL_W-1:0] PAT [6] = '{
    40'h00_0000_0000, 40'h00_0000_0001, 40'h7F_FFFF_FFFF,
    40'h80_0000_0000, 40'h00_8000_0000, 40'hFF_7FFF_FFFF
  };

  initial begin
    logic prev;
    logic e;
    repeat (3) @(negedge clk);
    check("R1", 1'b0); // reset state
    @(negedge clk);
    rst = 1'b0;

    // Vector table
    for (int i = 0; i < NVEC; i++) begin
      apply(1'b1, VEC[i][49:47], VEC[i][46:45], VEC[i][44], VEC[i][43],
            VEC[i][42], VEC[i][41], VEC[i][40:1]);
      check(req_of(VEC[i][49:47]), VEC[i][0]);
    end

    // Sweep all six modes, four classes, several result patterns
    for (int m = 0; m < 6; m++) begin
      for (int c = 0; c < 4; c++) begin
        for (int p = 0; p < 6; p++) begin
          prev = dc;
          e = ref_dc(m[2:0], c[1:0], p[0], p[0] ^ p[2], p[1], !p[0], PAT[p], prev);
          apply(1'b1, m[2:0], c[1:0], p[0], p[0] ^ p[2], p[1], !p[0], PAT[p]);
          check(req_of(m[2:0]), e);
        end
      end
    end

    // R2: write enable low holds DC (set it to 1 first)
    apply(1'b1, 3'd2, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0, '0);
    check("R5", 1'b1);
    apply(1'b0, 3'd2, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 40'h1);
    check("R2", 1'b1);
    apply(1'b1, 3'd2, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 40'h1);
    check("R5", 1'b0);
    apply(1'b0, 3'd2, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0, '0);
    check("R2", 1'b0);

    // R9: reserved modes hold 0 and 1
    apply(1'b1, 3'd6, 2'd0, 1'b0, 1'b0, 1'b1, 1'b1, '0);
    check("R9", 1'b0);
    apply(1'b1, 3'd0, 2'd0, 1'b0, 1'b0, 1'b1, 1'b0, 40'h1);
    check("R3", 1'b1);
    apply(1'b1, 3'd7, 2'd1, 1'b0, 1'b0, 1'b0, 1'b0, 40'h1);
    check("R9", 1'b1);
    apply(1'b1, 3'd6, 2'd3, 1'b0, 1'b0, 1'b0, 1'b0, 40'h1);
    check("R9", 1'b1);

    // R1: reset clears DC and wins over a write that would set it
    @(negedge clk);
    rst = 1'b1; wr_en = 1'b1; mode = 3'd0; op_class = 2'd0; carry_out = 1'b1;
    @(negedge clk);
    check("R1", 1'b0);
    rst = 1'b0; wr_en = 1'b0;
    @(negedge clk);
    check("R1", 1'b0);

    finish_run();
  end

endmodule